// File: doc/BRIEF.md
# Immediate Constant Builder Unit

This block executes a narrow family of 32-bit immediate-format instructions whose job is to assemble constants inside registers. It has a private register file of 32 entries of 32 bits. Each clock it may take one instruction word, qualified by a valid strobe. It splits the word into an opcode, a source register index, a target register index and a 16-bit immediate. It then computes the result and writes it to the target register on the next rising edge.

Three operations are understood: placing the immediate in the upper half of a word, OR-ing a register with a zero-extended immediate, and adding a sign-extended immediate. Pairing the upper-half load with the OR yields any 32-bit constant exactly. Pairing it with the add corrupts the upper half whenever the low immediate has its top bit set. Any other opcode raises an illegal flag and writes nothing. Two combinational read ports expose register contents.

Top module: `imm_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears every register, so after reset both read ports return 0 for any index.
- R2: Opcode 6'b001111 (bits 31:26) writes {imm[15:0], 16'h0000} to the register indexed by bits 20:16, whatever bits 25:21 hold.
- R3: Opcode 6'b001101 writes (source register, indexed by bits 25:21) OR (immediate zero-extended to 32 bits) to the target register; the target's upper half therefore equals the source's upper half.
- R4: Opcode 6'b001000 writes source register plus the immediate sign-extended from bit 15, wrapping modulo 2^32 with no trap; upper-half load of 0x0123 followed by this with 0xABCD gives 0x0122ABCD.
- R5: Register 0 always reads as zero; any write aimed at it is dropped.
- R6: When valid is high and the opcode is none of the three above, the illegal output is high in that same cycle and no register changes.
- R7: When valid is low no register changes and illegal is low.
- R8: A write lands on the rising edge where valid is high and is visible on both read ports right after that edge; an instruction in the next cycle reads the updated source value.
- R9: Upper-half load followed by OR-immediate on the same register produces the exact 32-bit constant (0x0123 then 0xABCD gives 0x0123ABCD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data (combinational) |
| illegal | output | 1 | Valid instruction carries an unsupported opcode |

## Verification
Every cycle the assertions check that illegal or idle cycles raise no write enable, that an upper-half load always carries a zero low half, that an OR-immediate keeps the source's upper half, and that each accepted nonzero write is stored exactly. The arithmetic itself, the sign-extension corruption of the add path, the dropping of writes to register 0 and the two-instruction constant sequences can only be shown by the bench's scenarios. The bench compares the read ports against a register model driven by its own extension functions.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
  localparam int XLEN     = 32;
  localparam int IMM_W    = 16;
  localparam int OPC_W    = 6;
  localparam int IDX_W    = 5;

  localparam logic [OPC_W-1:0] OPC_UPPER = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_UPPER = 2'd1,
    OP_OR    = 2'd2,
    OP_ADD   = 2'd3
  } op_kind_e;

  typedef struct packed {
    op_kind_e           kind;
    logic [IDX_W-1:0]   src;
    logic [IDX_W-1:0]   dst;
    logic [IMM_W-1:0]   imm;
  } dec_t;

  function automatic logic [XLEN-1:0] fn_upper(input logic [IMM_W-1:0] imm);
    return {imm, {(XLEN-IMM_W){1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] fn_zext(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] fn_sext(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] fn_or(input logic [XLEN-1:0] a,
                                            input logic [IMM_W-1:0] imm);
    return a | fn_zext(imm);
  endfunction

  function automatic logic [XLEN-1:0] fn_add(input logic [XLEN-1:0] a,
                                             input logic [IMM_W-1:0] imm);
    return a + fn_sext(imm);
  endfunction
endpackage

// File: rtl/imm_exec_decode.sv
module imm_exec_decode
  import imm_exec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output dec_t              dec,
  output logic              wr_req,
  output logic              bad_op
);
  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int SRC_LSB = OPC_LSB - IDX_W;
  localparam int DST_LSB = SRC_LSB - IDX_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = word[WORD_W-1:OPC_LSB];
    dec.src = word[OPC_LSB-1:SRC_LSB];
    dec.dst = word[SRC_LSB-1:DST_LSB];
    dec.imm = word[IMM_W-1:0];
    unique case (opc)
      OPC_UPPER: dec.kind = OP_UPPER;
      OPC_ORI:   dec.kind = OP_OR;
      OPC_ADDI:  dec.kind = OP_ADD;
      default:   dec.kind = OP_NONE;
    endcase
    bad_op = valid && (dec.kind == OP_NONE);
    wr_req = valid && (dec.kind != OP_NONE);
  end
endmodule

// File: rtl/imm_exec_alu.sv
module imm_exec_alu
  import imm_exec_pkg::*;
(
  input  op_kind_e          kind,
  input  logic [XLEN-1:0]   src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [XLEN-1:0]   result
);
  always_comb begin
    unique case (kind)
      OP_UPPER: result = fn_upper(imm);
      OP_OR:    result = fn_or(src_val, imm);
      OP_ADD:   result = fn_add(src_val, imm);
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/imm_exec_regfile.sv
module imm_exec_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_s,
  output logic [DATA_W-1:0] rdata_s,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  assign mem[0] = '0;

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        mem[gi] <= '0;
      else if (we && (waddr == AW'(gi)))
        mem[gi] <= wdata;
    end
  end

  assign rdata_s = mem[raddr_s];
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R8: an accepted write to a real register holds the written value after the edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [31:0]     instr_word,
  input  logic [AW-1:0]   rd_addr_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [AW-1:0]   rd_addr_b,
  output logic [XLEN-1:0] rd_data_b,
  output logic            illegal
);
  dec_t            dec;
  logic            wr_en;
  logic            bad_op;
  logic [XLEN-1:0] src_val;
  logic [XLEN-1:0] wr_data;

  imm_exec_decode #(.WORD_W(32)) u_dec (
    .valid  (instr_valid),
    .word   (instr_word),
    .dec    (dec),
    .wr_req (wr_en),
    .bad_op (bad_op)
  );

  imm_exec_alu u_alu (
    .kind    (dec.kind),
    .src_val (src_val),
    .imm     (dec.imm),
    .result  (wr_data)
  );

  imm_exec_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (dec.dst[AW-1:0]),
    .wdata   (wr_data),
    .raddr_s (dec.src[AW-1:0]),
    .rdata_s (src_val),
    .raddr_a (rd_addr_a),
    .rdata_a (rd_data_a),
    .raddr_b (rd_addr_b),
    .rdata_b (rd_data_b)
  );

  assign illegal = bad_op;

  // R6: an unsupported opcode never reaches the register file
  a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_en);

  // R7: idle cycles neither write nor flag
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!wr_en && !illegal));

  // R2: upper-half load always delivers a zero low half
  a_r2_low_half_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dec.kind == OP_UPPER) |-> (wr_data[15:0] == 16'h0000));

  // R3: OR-immediate leaves the source's upper half untouched
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dec.kind == OP_OR) |-> (wr_data[31:16] == src_val[31:16]));
endmodule

// File: tb/imm_exec_unit_bench.sv
module imm_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [4:0]  rd_addr_a, rd_addr_b;
  logic [31:0] rd_data_a, rd_data_b;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #5 clk = ~clk;

  imm_exec_unit u_imm_exec_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .illegal(illegal)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] s,
                                      input logic [4:0] t, input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  // bench's own view of the three operations
  function automatic logic [31:0] ref_result(input logic [31:0] w, input logic [31:0] sv);
    logic [15:0] k;
    k = w[15:0];
    if (w[31:26] == 6'b001111) return {k, 16'd0};
    if (w[31:26] == 6'b001101) return {sv[31:16], sv[15:0] | k};
    return sv + (k[15] ? {16'hFFFF, k} : {16'h0000, k});
  endfunction

  function automatic bit is_legal(input logic [5:0] op);
    return op == 6'b001111 || op == 6'b001101 || op == 6'b001000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one instruction, check flag, then read back target and a random register
  task automatic exec(input logic [31:0] w, input string req);
    logic [4:0] t;
    logic [4:0] other;
    logic [31:0] exp;
    t = w[20:16];
    other = 5'($urandom_range(0, 31));
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    #1;
    check(is_legal(w[31:26]) ? "R7/R2-R4 illegal low" : "R6 illegal high",
          {31'd0, illegal}, {31'd0, !is_legal(w[31:26])});
    exp = ref_result(w, model[w[25:21]]);
    @(posedge clk);
    if (is_legal(w[31:26]) && t != 5'd0) model[t] = exp;
    @(negedge clk);
    instr_valid = 1'b0;
    rd_addr_a = t;
    rd_addr_b = other;
    #1;
    check(req, rd_data_a, model[t]);
    check("R8 port B", rd_data_b, model[other]);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    rst = 1'b1; instr_valid = 1'b0; instr_word = 32'hFFFF_FFFF;
    rd_addr_a = 5'd0; rd_addr_b = 5'd0;
    // preload garbage so that reset has something to clear
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    instr_valid = 1'b1; instr_word = enc(6'b001111, 5'd0, 5'd9, 16'hDEAD);
    @(negedge clk); instr_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i); #1;
      check("R1 reset port A", rd_data_a, 32'd0);
      check("R1 reset port B", rd_data_b, 32'd0);
    end

    // R9: exact constant via upper load then OR
    exec(enc(6'b001111, 5'd17, 5'd8, 16'h0123), "R2 upper load rs ignored");
    check("R2 value", model[8], 32'h0123_0000);
    exec(enc(6'b001101, 5'd8, 5'd8, 16'hABCD), "R9 upper+or constant");
    check("R9 exact", rd_data_a, 32'h0123_ABCD);
    // R4: upper load then add with negative immediate
    exec(enc(6'b001111, 5'd3, 5'd1, 16'h0123), "R2 upper load");
    exec(enc(6'b001000, 5'd1, 5'd1, 16'hABCD), "R4 add sign-extended");
    check("R4 exact", rd_data_a, 32'h0122_ABCD);
    // R4 wrap
    exec(enc(6'b001111, 5'd0, 5'd2, 16'hFFFF), "R2 upper load");
    exec(enc(6'b001000, 5'd2, 5'd2, 16'h7FFF), "R4 add positive");
    exec(enc(6'b001000, 5'd2, 5'd2, 16'h8001), "R4 add wraps");
    exec(enc(6'b001101, 5'd2, 5'd4, 16'h0000), "R3 or copies source");
    // R5: writes to register 0 are dropped
    exec(enc(6'b001111, 5'd0, 5'd0, 16'h5A5A), "R5 zero stays zero");
    exec(enc(6'b001101, 5'd8, 5'd0, 16'hFFFF), "R5 zero stays zero");
    exec(enc(6'b001000, 5'd0, 5'd5, 16'hFFFE), "R5 zero source add");
    check("R5 source reads zero", rd_data_a, 32'hFFFF_FFFE);
    // R6: unsupported opcodes leave target intact
    exec(enc(6'b100011, 5'd8, 5'd8, 16'h1111), "R6 target unchanged");
    check("R6 keep", rd_data_a, 32'h0123_ABCD);
    exec(enc(6'b000000, 5'd1, 5'd1, 16'hFFFF), "R6 target unchanged");
    // R7: idle cycle with a legal-looking word does nothing
    @(negedge clk);
    instr_valid = 1'b0; instr_word = enc(6'b001111, 5'd0, 5'd8, 16'hBEEF);
    #1; check("R7 idle illegal low", {31'd0, illegal}, 32'd0);
    @(negedge clk); rd_addr_a = 5'd8; #1;
    check("R7 idle no write", rd_data_a, 32'h0123_ABCD);

    // R8: back-to-back dependent instructions
    @(negedge clk);
    instr_valid = 1'b1; instr_word = enc(6'b001111, 5'd0, 5'd6, 16'h1234);
    @(negedge clk);
    instr_word = enc(6'b001101, 5'd6, 5'd7, 16'h5678);
    @(negedge clk);
    instr_valid = 1'b0; rd_addr_a = 5'd7; rd_addr_b = 5'd6; #1;
    model[6] = 32'h1234_0000; model[7] = 32'h1234_5678;
    check("R8 back-to-back", rd_data_a, 32'h1234_5678);
    check("R8 first write", rd_data_b, 32'h1234_0000);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] op;
      int sel;
      sel = int'($urandom_range(0, 9));
      op = (sel < 3) ? 6'b001111 : (sel < 6) ? 6'b001101 :
           (sel < 9) ? 6'b001000 : 6'($urandom);
      exec(enc(op, 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
               16'($urandom)), "R2-R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule